// File: doc/BRIEF.md
# Priority-Threshold Interrupt Router

This block gathers a set of level-sensitive interrupt request lines and steers each one to one of two processor interrupt outputs. One output is a fast interrupt line and the other is a standard interrupt line. Every source has a small configuration register. The register picks the source's destination output and gives it a 4-bit priority. It also holds a sticky request bit that software sets, which lets software stand in for the hardware device.

Each destination has its own priority threshold. A pending source counts for its destination only when its priority is strictly above that destination's threshold. Priority 0 therefore never gets through. Among the sources that pass, the highest priority wins, and on a tie the lowest source index wins. For each destination the block gives a registered request line, the winning source index and the winning priority. A plain write/read register port holds the whole configuration.

Top module: `irq_prio_router`

## Requirements
- R1: Bit 4 of a source's configuration register selects its destination: 0 sends it to the fast output (`fiq_*`) and 1 sends it to the standard output (`irq_*`). A source never affects the other destination.
- R2: A source whose priority field (bits 3:0) is 0 never asserts either output, whatever its request state.
- R3: A source counts only when its priority is strictly greater than its destination's threshold. A threshold of 15 blocks every source on that destination. A threshold of 0 passes every nonzero priority.
- R4: Among the qualifying sources of one destination, the one with the numerically highest priority wins (15 highest, 1 lowest). Its index and priority appear on that destination's outputs.
- R5: When qualifying sources of one destination share the top priority, the lowest source index wins.
- R6: A source is pending when its hardware line is high or its software request bit (bit 5 of its configuration register) is set. The software bit stays set until software writes it to 0.
- R7: The outputs are registered. A change on the hardware request lines shows on the outputs after exactly one rising clock edge. A register write reaches the outputs one edge after the register takes it.
- R8: A destination with no qualifying source drives its line low, its index 0 and its priority 0.
- R9: After reset, all configuration registers and both thresholds read 0, and both output lines are low.
- R10: Register map:
  - Addresses 0 to NUM_SRC-1 hold the source configurations in the layout [5] software request, [4] destination, [3:0] priority.
  - Address NUM_SRC holds the fast threshold and address NUM_SRC+1 the standard threshold, each in bits [3:0].
  - Reads return the stored fields, with unused bits read as 0.
  - Writes to any other address are ignored, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | NUM_SRC | Level-sensitive hardware request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| fiq_o | output | 1 | Fast interrupt request |
| fiq_idx_o | output | IDX_W | Winning source index on the fast output |
| fiq_prio_o | output | 4 | Winning priority on the fast output |
| irq_o | output | 1 | Standard interrupt request |
| irq_idx_o | output | IDX_W | Winning source index on the standard output |
| irq_prio_o | output | 4 | Winning priority on the standard output |

## Verification
The bench builds the block with its default of eight sources. With eight sources both threshold registers and the unmapped addresses up to 15 are reachable on the 4-bit address. Eight sources also allow two equal-priority sources, a masked zero-priority source and a source below its threshold on each destination at once. Both destinations resolve together in one vector, so the bench can see that they never influence each other.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int PRIO_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_TGT = 2;
    localparam int TGT_FAST = 0;
    localparam int TGT_STD  = 1;

    typedef logic [PRIO_W-1:0] prio_t;

    // Layout matches the register map: [5] soft request, [4] destination, [3:0] priority
    typedef struct packed {
        logic  swreq;
        logic  tgt;
        prio_t prio;
    } src_cfg_t;

    localparam int CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = $clog2(NUM_SRC + 2)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output src_cfg_t [NUM_SRC-1:0]  cfg_o,
    output prio_t [NUM_TGT-1:0]     thr_o
);
    localparam int THR_BASE = NUM_SRC;

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] src;
        prio_t [NUM_TGT-1:0]    thr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr_i == ADDR_W'(i)) begin
                    regs_d.src[i] = src_cfg_t'(wdata_i[CFG_W-1:0]);
                end
            end
            for (int t = 0; t < NUM_TGT; t++) begin
                if (addr_i == ADDR_W'(THR_BASE + t)) begin
                    regs_d.thr[t] = wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr_i == ADDR_W'(i)) begin
                rdata_o = DATA_W'(regs_q.src[i]);
            end
        end
        for (int t = 0; t < NUM_TGT; t++) begin
            if (addr_i == ADDR_W'(THR_BASE + t)) begin
                rdata_o = DATA_W'(regs_q.thr[t]);
            end
        end
    end

    assign cfg_o = regs_q.src;
    assign thr_o = regs_q.thr;
endmodule

// File: rtl/irq_target_arb.sv
module irq_target_arb
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    parameter int TGT     = 0
) (
    input  logic [NUM_SRC-1:0]      pending_i,
    input  src_cfg_t [NUM_SRC-1:0]  cfg_i,
    input  prio_t                   thr_i,
    output logic                    valid_o,
    output logic [IDX_W-1:0]        idx_o,
    output prio_t                   prio_o
);
    localparam logic TGT_BIT = 1'(TGT);

    logic [NUM_SRC-1:0] elig;

    // A source qualifies when pending, routed here and strictly above threshold
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = pending_i[g] && (cfg_i[g].tgt == TGT_BIT) && (cfg_i[g].prio > thr_i);
    end

    always_comb begin
        prio_o = '0;
        idx_o  = '0;
        // Ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (cfg_i[i].prio > prio_o)) begin
                prio_o = cfg_i[i].prio;
                idx_o  = IDX_W'(i);
            end
        end
        valid_o = (prio_o != '0);
    end
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = $clog2(NUM_SRC + 2),
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] hw_req_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    output logic               fiq_o,
    output logic [IDX_W-1:0]   fiq_idx_o,
    output logic [3:0]         fiq_prio_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o,
    output logic [3:0]         irq_prio_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        prio_t            prio;
    } win_t;

    typedef struct packed {
        win_t [NUM_TGT-1:0] win;
    } out_t;

    src_cfg_t [NUM_SRC-1:0] cfg_w;
    prio_t [NUM_TGT-1:0]    thr_w;
    logic [NUM_SRC-1:0]     pending_w;
    win_t [NUM_TGT-1:0]     arb_w;
    out_t                   out_d, out_q;

    irq_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) cfg_regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .cfg_o   (cfg_w),
        .thr_o   (thr_w)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
        assign pending_w[g] = hw_req_i[g] | cfg_w[g].swreq;
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_arb
        irq_target_arb #(
            .NUM_SRC (NUM_SRC),
            .IDX_W   (IDX_W),
            .TGT     (t)
        ) arb_i (
            .pending_i (pending_w),
            .cfg_i     (cfg_w),
            .thr_i     (thr_w[t]),
            .valid_o   (arb_w[t].valid),
            .idx_o     (arb_w[t].idx),
            .prio_o    (arb_w[t].prio)
        );
    end

    always_comb begin
        out_d = out_q;
        for (int t = 0; t < NUM_TGT; t++) begin
            out_d.win[t] = arb_w[t];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fiq_o      = out_q.win[TGT_FAST].valid;
    assign fiq_idx_o  = out_q.win[TGT_FAST].idx;
    assign fiq_prio_o = out_q.win[TGT_FAST].prio;
    assign irq_o      = out_q.win[TGT_STD].valid;
    assign irq_idx_o  = out_q.win[TGT_STD].idx;
    assign irq_prio_o = out_q.win[TGT_STD].prio;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fiq_o,
    input logic [IDX_W-1:0] fiq_idx_o,
    input logic [3:0]       fiq_prio_o,
    input logic             irq_o,
    input logic [IDX_W-1:0] irq_idx_o,
    input logic [3:0]       irq_prio_o,
    input logic [3:0]       thr_fast_i,
    input logic [3:0]       thr_std_i
);
    assert_fast_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o |-> (fiq_prio_o != 4'd0));

    assert_std_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (irq_prio_o != 4'd0));

    assert_fast_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fiq_o |-> (fiq_idx_o == '0 && fiq_prio_o == 4'd0));

    assert_std_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (irq_idx_o == '0 && irq_prio_o == 4'd0));

    assert_fast_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thr_fast_i == 4'd15) |=> !fiq_o);

    assert_std_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (thr_std_i == 4'd15) |=> !irq_o);

    assert_fast_above_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && fiq_o) |-> (fiq_prio_o > $past(thr_fast_i)));

    assert_one_dest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fiq_o && irq_o) |-> (fiq_idx_o != irq_idx_o));
endmodule

bind irq_prio_router irq_router_chk #(.IDX_W(IDX_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fiq_o      (fiq_o),
    .fiq_idx_o  (fiq_idx_o),
    .fiq_prio_o (fiq_prio_o),
    .irq_o      (irq_o),
    .irq_idx_o  (irq_idx_o),
    .irq_prio_o (irq_prio_o),
    .thr_fast_i (thr_w[0]),
    .thr_std_i  (thr_w[1])
);

// File: tb/irq_prio_router_tb.sv
module irq_prio_router_tb_top;
    localparam int N  = 8;
    localparam int AW = 4;
    localparam int IW = 3;
    localparam int NV = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  hw_req = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          fiq, irq;
    logic [IW-1:0] fidx, iidx;
    logic [3:0]    fprio, iprio;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_prio_router dut_i (
        .clk_i (clk), .rst_ni (rst_n), .hw_req_i (hw_req),
        .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
        .fiq_o (fiq), .fiq_idx_o (fidx), .fiq_prio_o (fprio),
        .irq_o (irq), .irq_idx_o (iidx), .irq_prio_o (iprio)
    );

    // {hw_req, fiq, fidx, fprio, irq, iidx, iprio}
    localparam logic [23:0] VEC [NV] = '{
        {8'b0000_0000, 1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0 },
        {8'b0000_0001, 1'b1, 3'd0, 4'd3,  1'b0, 3'd0, 4'd0 },
        {8'b0000_0110, 1'b1, 3'd1, 4'd7,  1'b0, 3'd0, 4'd0 },
        {8'b0000_1000, 1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0 },
        {8'b0100_0000, 1'b0, 3'd0, 4'd0,  1'b0, 3'd0, 4'd0 },
        {8'b0001_0000, 1'b0, 3'd0, 4'd0,  1'b1, 3'd4, 4'd5 },
        {8'b1011_0111, 1'b1, 3'd7, 4'd9,  1'b1, 3'd5, 4'd15},
        {8'b1111_1111, 1'b1, 3'd7, 4'd9,  1'b1, 3'd5, 4'd15},
        {8'b0000_0100, 1'b1, 3'd2, 4'd7,  1'b0, 3'd0, 4'd0 }
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = AW'(a); wdata = 8'(d);
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        @(negedge clk);
        addr = AW'(a);
        #1;
        check(req, 32'(rdata), 32'(exp));
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req, input logic [23:0] v);
        check({req, " fiq"},   32'(fiq),   32'(v[15]));
        check({req, " fidx"},  32'(fidx),  32'(v[14:12]));
        check({req, " fprio"}, 32'(fprio), 32'(v[11:8]));
        check({req, " irq"},   32'(irq),   32'(v[7]));
        check({req, " iidx"},  32'(iidx),  32'(v[6:4]));
        check({req, " iprio"}, 32'(iprio), 32'(v[3:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 fiq after reset", 32'(fiq), 0);
        check("R9 irq after reset", 32'(irq), 0);
        rst_n = 1'b1;
        rd_check("R9 cfg0 reset", 0, 0);
        rd_check("R9 thr fast reset", 8, 0);
        hw_req = '1;
        settle();
        check("R9 unconfigured fiq", 32'(fiq), 0);
        check("R9 unconfigured irq", 32'(irq), 0);
        hw_req = '0;

        // Configuration
        wr(0, 8'h03); wr(1, 8'h07); wr(2, 8'h07); wr(3, 8'h00);
        wr(4, 8'h15); wr(5, 8'h1F); wr(6, 8'h12); wr(7, 8'h09);
        wr(8, 2);     wr(9, 4);
        rd_check("R10 cfg5 readback", 5, 8'h1F);
        rd_check("R10 thr std readback", 9, 4);
        settle();

        // Vector table: R1 R2 R3 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            hw_req = VEC[k][23:16];
            settle();
            check_out($sformatf("R4/R5/R2/R3/R1/R8 vec%0d", k), VEC[k]);
        end

        // R7 one-edge latency
        hw_req = '0;
        settle();
        hw_req = 8'h01;
        #1;
        check("R7 no change before edge", 32'(fiq), 0);
        settle();
        check("R7 after one edge", 32'(fiq), 1);
        check("R7 prio after one edge", 32'(fprio), 3);

        // R6 software request
        hw_req = '0;
        wr(4, 8'h35);
        settle();
        check("R6 soft irq", 32'(irq), 1);
        check("R6 soft idx", 32'(iidx), 4);
        check("R6 soft prio", 32'(iprio), 5);
        repeat (3) settle();
        check("R6 soft sticky", 32'(irq), 1);
        rd_check("R6 soft readback", 4, 8'h35);
        wr(4, 8'h15);
        settle();
        check("R6 soft cleared", 32'(irq), 0);

        // R3 threshold corners
        hw_req = 8'h01;
        wr(8, 3);
        settle();
        check("R3 equal to threshold blocked", 32'(fiq), 0);
        wr(8, 0);
        settle();
        check("R3 threshold 0 passes", 32'(fiq), 1);
        check("R3 threshold 0 prio", 32'(fprio), 3);
        hw_req = '1;
        wr(8, 15);
        settle();
        check("R3 threshold 15 blocks", 32'(fiq), 0);
        check("R3 other dest unaffected", 32'(iprio), 15);
        wr(8, 2);

        // R1 retarget source 0 to the standard output
        hw_req = 8'h01;
        wr(0, 8'h13);
        wr(9, 0);
        settle();
        check("R1 retarget fiq", 32'(fiq), 0);
        check("R1 retarget irq", 32'(irq), 1);
        check("R1 retarget idx", 32'(iidx), 0);
        check("R1 retarget prio", 32'(iprio), 3);

        // R10 map corners
        wr(12, 8'hFF);
        rd_check("R10 unmapped read", 12, 0);
        rd_check("R10 cfg0 intact", 0, 8'h13);
        wr(1, 8'hC7);
        rd_check("R10 unused bits zero", 1, 8'h07);

        // R9 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 reset clears irq", 32'(irq), 0);
        rd_check("R9 reset clears cfg5", 5, 0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule